// File: doc/BRIEF.md
# Pipeline Advance and Hazard Controller

This block decides, every cycle, which stages of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) pass their instruction context to the next stage. A stage moves its context forward only when the stage after it can take it. The next stage can take it when it is empty, or when it is moving its own context on in the same cycle. Stages that cannot move hold their context and retry in the next cycle. A stall in one stage does not stop the stages after it, so an empty slot (a bubble) forms behind the stall.

Several sources can stall a stage: a per-stage stall request, a load-use dependency seen in decode, and a failed stage reservation. A fetch-side cache miss freezes the pipeline. Only fetch can set the freeze, and only fetch releases it, on its next successful cache access. Stages can also be reserved by a tagged instruction. A reserved stage accepts a context only from the instruction that holds the reservation, and only that instruction can release it. The block also produces decode's operand-forwarding selects and one stall-reason code per cycle for counting stalls by category.

All advance, bubble, forwarding and reason outputs are combinational from the current inputs and two pieces of state: the freeze flag and the reservation table. Both pieces of state update at the rising clock edge.

Top module: `pipe_adv_ctrl`

## Requirements
- R1: Stage index 0 is fetch, 1 decode, 2 execute, 3 memory, 4 writeback. Stage i<4 advances (adv_o[i]=1) only when it is valid, is not stalled, is not blocked by a reservation, and stage i+1 is either invalid or advancing itself.
- R2: When a valid stage does not advance, no stage upstream of it that is valid and has a valid successor advances. Those stages keep their contexts and retry in the next cycle.
- R3: bubble_o[i] (i=1..4) is 1 when stage i ends the cycle empty: it is empty or advancing, and stage i-1 is not advancing. A stall therefore leaves a bubble right after the stalled stage.
- R4: A valid writeback stage always advances (retires), even while the pipeline is frozen.
- R5: If decode is valid, execute is valid, writes a register, and has a type equal to LOAD_TYPE (default 1), and execute's destination is non-zero and equals either decode source, then decode and fetch do not advance.
- R6: Forward selects use these codes: 0 = register file, 1 = execute result, 2 = memory result. A source matches a stage when that stage is valid, writes a register, and has a destination equal to the source. When both stages match, execute wins.
- R7: Register 0 never causes a load-use stall and never selects forwarding.
- R8: In a cycle with a fetch cache miss (ic_req_i=1, ic_hit_i=0), fetch, decode, execute and memory all hold.
- R9: After a miss, the pipeline stays frozen (decode through memory hold) until a cycle with ic_req_i=1 and ic_hit_i=1. That hit releases the freeze in the same cycle. A hit while not frozen has no effect.
- R10: A reservation request for stage 1..4 is granted (rsv_grant_o=1) when that stage is free or already held by the same tag. Otherwise it is refused, and decode and fetch stall. From the next cycle on, the reserved stage accepts a context only from a predecessor whose tag equals the reservation tag.
- R11: A release frees only the stages whose reservation tag equals the release tag, effective from the next cycle. A release with any other tag changes nothing.
- R12: stall_code_o reports the highest-priority reason active in the cycle: 1 cache miss, 2 load-use, 3 reservation refused, 4 frozen without a new miss, 5 external stall request, 0 none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stg_vld_i | input | NSTG | Stage holds a valid context (bit 0 = fetch) |
| stg_stall_i | input | NSTG-1 | External stall request, fetch through memory |
| stg_tag_i | input | (NSTG-1)*TAG_W | Instruction tags of fetch through memory, fetch in the low bits |
| ex_type_i | input | TYPE_W | Instruction type in execute |
| ex_wr_i | input | 1 | Execute instruction writes a register |
| ex_dst_i | input | REG_W | Execute destination register |
| mem_wr_i | input | 1 | Memory-stage instruction writes a register |
| mem_dst_i | input | REG_W | Memory-stage destination register |
| id_src_a_i | input | REG_W | Decode first source register |
| id_src_b_i | input | REG_W | Decode second source register |
| ic_req_i | input | 1 | Fetch accesses the instruction cache this cycle |
| ic_hit_i | input | 1 | That access completed |
| rsv_req_i | input | 1 | Reservation request |
| rsv_stg_i | input | SW | Stage index to reserve |
| rsv_tag_i | input | TAG_W | Tag of the reserving instruction |
| rsv_rel_i | input | 1 | Reservation release request |
| rsv_rel_tag_i | input | TAG_W | Tag of the releasing instruction |
| adv_o | output | NSTG | Per-stage advance enable |
| bubble_o | output | NSTG-1 | Stage 1..4 is empty next cycle |
| fwd_a_o | output | 2 | Forward select, first source |
| fwd_b_o | output | 2 | Forward select, second source |
| stall_code_o | output | 3 | Stall reason code |
| rsv_grant_o | output | 1 | Reservation request granted |

## Verification
Advance, bubble, forwarding, grant and reason outputs react to their inputs in the same cycle. The bench therefore drives inputs at the falling edge and samples them 2 ns later, well before the next rising edge. Freeze and reservation changes take effect one rising edge later. Their checks are taken in the following low phase, with unchanged inputs where the check is about held state. This is how the same-cycle unfreeze on a hit, the next-cycle effect of a grant, and a release with a wrong tag having no effect are each checked in the cycle where they are due.

// File: rtl/pac_pkg.sv
package pac_pkg;
  typedef enum logic [2:0] {
    STL_NONE    = 3'd0,
    STL_ICMISS  = 3'd1,
    STL_LDUSE   = 3'd2,
    STL_RSVFULL = 3'd3,
    STL_FROZEN  = 3'd4,
    STL_EXT     = 3'd5
  } stall_code_e;

  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_EX  = 2'd1,
    FWD_MEM = 2'd2
  } fwd_sel_e;

  localparam int ID_S  = 1;
  localparam int EX_S  = 2;
  localparam int MEM_S = 3;
endpackage

// File: rtl/pac_hazard.sv
module pac_hazard
  import pac_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter int TYPE_W    = 2,
  parameter int LOAD_TYPE = 1
) (
  input  logic              id_vld_i,
  input  logic [REG_W-1:0]  src_a_i,
  input  logic [REG_W-1:0]  src_b_i,
  input  logic              ex_vld_i,
  input  logic              ex_wr_i,
  input  logic [TYPE_W-1:0] ex_type_i,
  input  logic [REG_W-1:0]  ex_dst_i,
  input  logic              mem_vld_i,
  input  logic              mem_wr_i,
  input  logic [REG_W-1:0]  mem_dst_i,
  output logic              ld_use_o,
  output fwd_sel_e          fwd_a_o,
  output fwd_sel_e          fwd_b_o
);
  localparam logic [TYPE_W-1:0] LD_T = TYPE_W'(LOAD_TYPE);

  logic ex_live, mem_live;
  logic [1:0] ex_hit, mem_hit;
  logic [REG_W-1:0] src [2];
  fwd_sel_e sel [2];

  assign src[0]   = src_a_i;
  assign src[1]   = src_b_i;
  assign ex_live  = ex_vld_i & ex_wr_i & (ex_dst_i != '0);
  assign mem_live = mem_vld_i & mem_wr_i & (mem_dst_i != '0);

  for (genvar s = 0; s < 2; s++) begin : g_src
    assign ex_hit[s]  = ex_live & (ex_dst_i == src[s]);
    assign mem_hit[s] = mem_live & (mem_dst_i == src[s]);
    always_comb begin
      if (ex_hit[s])       sel[s] = FWD_EX;
      else if (mem_hit[s]) sel[s] = FWD_MEM;
      else                 sel[s] = FWD_RF;
    end
  end

  assign fwd_a_o  = sel[0];
  assign fwd_b_o  = sel[1];
  assign ld_use_o = id_vld_i & (ex_type_i == LD_T) & (|ex_hit);
endmodule

// File: rtl/pac_freeze.sv
module pac_freeze (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ic_req_i,
  input  logic ic_hit_i,
  output logic ic_miss_o,
  output logic frozen_o
);
  logic frozen_q, ic_ok;

  assign ic_miss_o = ic_req_i & ~ic_hit_i;
  assign ic_ok     = ic_req_i & ic_hit_i;
  // only fetch's own hit clears; a hit while thawed leaves state at 0
  assign frozen_o  = ic_miss_o | (frozen_q & ~ic_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frozen_q <= 1'b0;
    else         frozen_q <= frozen_o;
  end
endmodule

// File: rtl/pac_resv.sv
module pac_resv #(
  parameter int NSTG  = 5,
  parameter int TAG_W = 8,
  localparam int SW   = $clog2(NSTG)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic [SW-1:0]               req_stg_i,
  input  logic [TAG_W-1:0]            req_tag_i,
  input  logic                        rel_i,
  input  logic [TAG_W-1:0]            rel_tag_i,
  output logic                        grant_o,
  output logic [NSTG-1:1]             held_o,
  output logic [(NSTG-1)*TAG_W-1:0]   owner_o
);
  logic [NSTG-1:1] pick;

  for (genvar i = 1; i < NSTG; i++) begin : g_slot
    logic             v_q;
    logic [TAG_W-1:0] t_q;
    logic             free_ok, drop;

    assign free_ok = ~v_q | (t_q == req_tag_i);
    assign pick[i] = req_i & (req_stg_i == SW'(i)) & free_ok;
    assign drop    = rel_i & v_q & (t_q == rel_tag_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        t_q <= '0;
      end else if (pick[i]) begin
        v_q <= 1'b1;
        t_q <= req_tag_i;
      end else if (drop) begin
        v_q <= 1'b0;
      end
    end

    assign held_o[i] = v_q;
    assign owner_o[(i-1)*TAG_W +: TAG_W] = t_q;
  end

  assign grant_o = |pick;
endmodule

// File: rtl/pac_advance.sv
module pac_advance #(
  parameter int NSTG  = 5,
  parameter int TAG_W = 8
) (
  input  logic [NSTG-1:0]             vld_i,
  input  logic [NSTG-2:0]             hold_i,
  input  logic [NSTG-1:1]             held_i,
  input  logic [(NSTG-1)*TAG_W-1:0]   owner_i,
  input  logic [(NSTG-1)*TAG_W-1:0]   tag_i,
  output logic [NSTG-1:0]             send_o,
  output logic [NSTG-1:1]             bubble_o
);
  logic [NSTG-1:1] blk;

  // owner_i slot i-1 is stage i; tag_i slot i-1 is the sender into stage i
  for (genvar i = 1; i < NSTG; i++) begin : g_blk
    assign blk[i] = held_i[i] &
                    (owner_i[(i-1)*TAG_W +: TAG_W] != tag_i[(i-1)*TAG_W +: TAG_W]);
  end

  always_comb begin
    logic go;
    go = vld_i[NSTG-1];
    send_o[NSTG-1] = go;
    for (int i = NSTG-2; i >= 0; i--) begin
      go = vld_i[i] & ~hold_i[i] & ~blk[i+1] & (~vld_i[i+1] | go);
      send_o[i] = go;
    end
  end

  for (genvar i = 1; i < NSTG; i++) begin : g_bub
    assign bubble_o[i] = (~vld_i[i] | send_o[i]) & ~send_o[i-1];
  end
endmodule

// File: rtl/pipe_adv_ctrl.sv
module pipe_adv_ctrl
  import pac_pkg::*;
#(
  parameter int NSTG      = 5,
  parameter int REG_W     = 5,
  parameter int TAG_W     = 8,
  parameter int TYPE_W    = 2,
  parameter int LOAD_TYPE = 1,
  localparam int SW       = $clog2(NSTG)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NSTG-1:0]           stg_vld_i,
  input  logic [NSTG-2:0]           stg_stall_i,
  input  logic [(NSTG-1)*TAG_W-1:0] stg_tag_i,
  input  logic [TYPE_W-1:0]         ex_type_i,
  input  logic                      ex_wr_i,
  input  logic [REG_W-1:0]          ex_dst_i,
  input  logic                      mem_wr_i,
  input  logic [REG_W-1:0]          mem_dst_i,
  input  logic [REG_W-1:0]          id_src_a_i,
  input  logic [REG_W-1:0]          id_src_b_i,
  input  logic                      ic_req_i,
  input  logic                      ic_hit_i,
  input  logic                      rsv_req_i,
  input  logic [SW-1:0]             rsv_stg_i,
  input  logic [TAG_W-1:0]          rsv_tag_i,
  input  logic                      rsv_rel_i,
  input  logic [TAG_W-1:0]          rsv_rel_tag_i,
  output logic [NSTG-1:0]           adv_o,
  output logic [NSTG-1:1]           bubble_o,
  output logic [1:0]                fwd_a_o,
  output logic [1:0]                fwd_b_o,
  output logic [2:0]                stall_code_o,
  output logic                      rsv_grant_o
);
  logic ld_use, ic_miss, frozen, rsv_fail;
  fwd_sel_e fa, fb;
  logic [NSTG-1:1] held;
  logic [(NSTG-1)*TAG_W-1:0] owner;
  logic [NSTG-2:0] hold;
  stall_code_e code;

  pac_hazard #(.REG_W(REG_W), .TYPE_W(TYPE_W), .LOAD_TYPE(LOAD_TYPE)) u_haz (
    .id_vld_i  (stg_vld_i[ID_S]),
    .src_a_i   (id_src_a_i),
    .src_b_i   (id_src_b_i),
    .ex_vld_i  (stg_vld_i[EX_S]),
    .ex_wr_i   (ex_wr_i),
    .ex_type_i (ex_type_i),
    .ex_dst_i  (ex_dst_i),
    .mem_vld_i (stg_vld_i[MEM_S]),
    .mem_wr_i  (mem_wr_i),
    .mem_dst_i (mem_dst_i),
    .ld_use_o  (ld_use),
    .fwd_a_o   (fa),
    .fwd_b_o   (fb)
  );

  pac_freeze u_frz (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ic_req_i  (ic_req_i),
    .ic_hit_i  (ic_hit_i),
    .ic_miss_o (ic_miss),
    .frozen_o  (frozen)
  );

  pac_resv #(.NSTG(NSTG), .TAG_W(TAG_W)) u_rsv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (rsv_req_i),
    .req_stg_i (rsv_stg_i),
    .req_tag_i (rsv_tag_i),
    .rel_i     (rsv_rel_i),
    .rel_tag_i (rsv_rel_tag_i),
    .grant_o   (rsv_grant_o),
    .held_o    (held),
    .owner_o   (owner)
  );

  assign rsv_fail = rsv_req_i & ~rsv_grant_o;

  // fetch owns the freeze; writeback is outside hold (never blocked)
  for (genvar i = 0; i < NSTG-1; i++) begin : g_hold
    if (i == 0) begin : g_if
      assign hold[i] = stg_stall_i[i] | ic_miss;
    end else if (i == ID_S) begin : g_id
      assign hold[i] = stg_stall_i[i] | frozen | ld_use | rsv_fail;
    end else begin : g_mid
      assign hold[i] = stg_stall_i[i] | frozen;
    end
  end

  pac_advance #(.NSTG(NSTG), .TAG_W(TAG_W)) u_adv (
    .vld_i    (stg_vld_i),
    .hold_i   (hold),
    .held_i   (held),
    .owner_i  (owner),
    .tag_i    (stg_tag_i),
    .send_o   (adv_o),
    .bubble_o (bubble_o)
  );

  always_comb begin
    if (ic_miss)           code = STL_ICMISS;
    else if (ld_use)       code = STL_LDUSE;
    else if (rsv_fail)     code = STL_RSVFULL;
    else if (frozen)       code = STL_FROZEN;
    else if (|stg_stall_i) code = STL_EXT;
    else                   code = STL_NONE;
  end

  assign stall_code_o = code;
  assign fwd_a_o      = fa;
  assign fwd_b_o      = fb;
endmodule

// File: rtl/pipe_adv_ctrl_chk.sv
module pipe_adv_ctrl_chk #(
  parameter int NSTG      = 5,
  parameter int REG_W     = 5,
  parameter int TYPE_W    = 2,
  parameter int LOAD_TYPE = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NSTG-1:0]   stg_vld_i,
  input logic [NSTG-1:0]   adv_o,
  input logic              ic_req_i,
  input logic              ic_hit_i,
  input logic [TYPE_W-1:0] ex_type_i,
  input logic              ex_wr_i,
  input logic [REG_W-1:0]  ex_dst_i,
  input logic [REG_W-1:0]  id_src_a_i,
  input logic [REG_W-1:0]  id_src_b_i,
  input logic [1:0]        fwd_a_o,
  input logic [1:0]        fwd_b_o
);
  for (genvar i = 0; i < NSTG-1; i++) begin : g_hs
    // R1
    handoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv_o[i] && stg_vld_i[i+1]) |-> adv_o[i+1]);
  end

  // R4
  retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stg_vld_i[NSTG-1] |-> adv_o[NSTG-1]);

  // R8
  miss_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ic_req_i && !ic_hit_i) |-> (adv_o[NSTG-2:0] == '0));

  // R9
  frozen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ic_req_i && $past(ic_req_i && !ic_hit_i)) |-> (adv_o[NSTG-2:1] == '0));

  // R5
  ld_use_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stg_vld_i[1] && stg_vld_i[2] && ex_wr_i && ex_type_i == TYPE_W'(LOAD_TYPE) &&
     ex_dst_i != '0 && (ex_dst_i == id_src_a_i || ex_dst_i == id_src_b_i))
    |-> !adv_o[1]);

  // R7
  zero_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_src_a_i == '0) |-> (fwd_a_o == 2'd0));

  // R7
  zero_reg_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_src_b_i == '0) |-> (fwd_b_o == 2'd0));
endmodule

bind pipe_adv_ctrl pipe_adv_ctrl_chk #(
  .NSTG(NSTG), .REG_W(REG_W), .TYPE_W(TYPE_W), .LOAD_TYPE(LOAD_TYPE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stg_vld_i  (stg_vld_i),
  .adv_o      (adv_o),
  .ic_req_i   (ic_req_i),
  .ic_hit_i   (ic_hit_i),
  .ex_type_i  (ex_type_i),
  .ex_wr_i    (ex_wr_i),
  .ex_dst_i   (ex_dst_i),
  .id_src_a_i (id_src_a_i),
  .id_src_b_i (id_src_b_i),
  .fwd_a_o    (fwd_a_o),
  .fwd_b_o    (fwd_b_o)
);

// File: tb/pipe_adv_ctrl_tb.sv
module pipe_adv_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  vld = '0;
  logic [3:0]  stl = '0;
  logic [31:0] tags = '0;
  logic [1:0]  ex_type = '0;
  logic        ex_wr = 1'b0, mem_wr = 1'b0;
  logic [4:0]  ex_dst = '0, mem_dst = '0, src_a = '0, src_b = '0;
  logic        ic_req = 1'b0, ic_hit = 1'b0;
  logic        rsv_req = 1'b0, rsv_rel = 1'b0;
  logic [2:0]  rsv_stg = '0;
  logic [7:0]  rsv_tag = '0, rel_tag = '0;
  logic [4:0]  adv;
  logic [4:1]  bub;
  logic [1:0]  fa, fb;
  logic [2:0]  code;
  logic        grant;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  pipe_adv_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .stg_vld_i(vld), .stg_stall_i(stl), .stg_tag_i(tags),
    .ex_type_i(ex_type), .ex_wr_i(ex_wr), .ex_dst_i(ex_dst), .mem_wr_i(mem_wr),
    .mem_dst_i(mem_dst), .id_src_a_i(src_a), .id_src_b_i(src_b), .ic_req_i(ic_req),
    .ic_hit_i(ic_hit), .rsv_req_i(rsv_req), .rsv_stg_i(rsv_stg), .rsv_tag_i(rsv_tag),
    .rsv_rel_i(rsv_rel), .rsv_rel_tag_i(rel_tag), .adv_o(adv), .bubble_o(bub),
    .fwd_a_o(fa), .fwd_b_o(fb), .stall_code_o(code), .rsv_grant_o(grant)
  );

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic idle();
    vld = '0; stl = '0; tags = '0; ex_type = '0; ex_wr = 0; mem_wr = 0;
    ex_dst = '0; mem_dst = '0; src_a = '0; src_b = '0; ic_req = 0; ic_hit = 0;
    rsv_req = 0; rsv_rel = 0; rsv_stg = '0; rsv_tag = '0; rel_tag = '0;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic t_reset();
    cyc(); idle(); #2;
    chk("reset adv", adv, 0);
    chk("reset code R12", code, 0);
    chk("reset fwd R6", {fa, fb}, 0);
  endtask

  task automatic t_flow();
    cyc(); idle(); vld = 5'h1f; #2;
    chk("R1 full flow adv", adv, 5'h1f);
    chk("R3 full flow bubble", bub, 4'b0000);
    cyc(); vld = 5'b11101; #2;
    chk("R1 hole in decode adv", adv, 5'b11101);
    chk("R3 hole bubble", bub, 4'b0010);
  endtask

  task automatic t_stall();
    cyc(); idle(); vld = 5'h1f; stl = 4'b1000; #2;
    chk("R2 memory stall adv", adv, 5'b10000);
    chk("R3 memory stall bubble", bub, 4'b1000);
    chk("R12 ext code", code, 5);
    cyc(); stl = 4'b0010; #2;
    chk("R2 decode stall adv", adv, 5'b11100);
    chk("R3 decode stall bubble", bub, 4'b0010);
  endtask

  task automatic t_load_use();
    cyc(); idle(); vld = 5'h1f; ex_type = 2'd1; ex_wr = 1; ex_dst = 5'd5; src_b = 5'd5; #2;
    chk("R5 load-use adv", adv, 5'b11100);
    chk("R12 load-use code", code, 2);
    cyc(); ex_type = 2'd0; #2;
    chk("R5 non-load no stall", adv, 5'h1f);
    chk("R6 fwd b from ex", fb, 1);
    cyc(); ex_type = 2'd1; ex_dst = 5'd0; src_a = 5'd0; src_b = 5'd0; #2;
    chk("R7 r0 load no stall", adv, 5'h1f);
    chk("R7 r0 no fwd", {fa, fb}, 0);
  endtask

  task automatic t_fwd();
    cyc(); idle(); vld = 5'h1f; ex_wr = 1; mem_wr = 1;
    ex_dst = 5'd3; mem_dst = 5'd3; src_a = 5'd3; src_b = 5'd9; #2;
    chk("R6 ex wins over mem", fa, 1);
    chk("R6 no match rf", fb, 0);
    cyc(); ex_dst = 5'd4; mem_dst = 5'd9; #2;
    chk("R6 fwd from mem", fb, 2);
    cyc(); mem_wr = 0; #2;
    chk("R6 mem not writing", fb, 0);
    cyc(); vld = 5'b10111; ex_dst = 5'd3; #2;
    chk("R6 invalid mem", fa, 1);
  endtask

  task automatic t_freeze();
    cyc(); idle(); vld = 5'h1f; ic_req = 1; #2;
    chk("R8 miss adv", adv, 5'b10000);
    chk("R12 miss code", code, 1);
    cyc(); ic_req = 0; #2;
    chk("R9 still frozen adv", adv, 5'b10000);
    chk("R12 frozen code", code, 4);
    cyc(); ic_req = 1; ic_hit = 1; #2;
    chk("R9 hit releases adv", adv, 5'h1f);
    chk("R9 hit code", code, 0);
    cyc(); ic_req = 0; ic_hit = 0; #2;
    chk("R9 released stays", adv, 5'h1f);
    cyc(); ic_req = 1; ic_hit = 1; #2;
    chk("R9 hit while thawed", adv, 5'h1f);
    cyc(); ic_hit = 0; ex_type = 2'd1; ex_wr = 1; ex_dst = 5'd6; src_a = 5'd6; stl = 4'b0100; #2;
    chk("R12 miss beats load-use", code, 1);
    cyc(); ic_hit = 1; #2;
    chk("R12 load-use beats ext", code, 2);
  endtask

  task automatic t_resv();
    cyc(); idle(); rsv_req = 1; rsv_stg = 3'd2; rsv_tag = 8'h11; #2;
    chk("R10 grant free stage", grant, 1);
    cyc(); rsv_req = 0; vld = 5'h1f; tags = 32'h0000_2200; #2;
    chk("R10 foreign tag blocked", adv, 5'b11100);
    cyc(); tags = 32'h0000_1100; #2;
    chk("R10 owner tag accepted", adv, 5'h1f);
    cyc(); tags = 32'h0000_2200; rsv_req = 1; rsv_tag = 8'h33; #2;
    chk("R10 busy refused", grant, 0);
    chk("R12 refused code", code, 3);
    cyc(); rsv_req = 0; rsv_rel = 1; rel_tag = 8'h22; #2;
    chk("R11 release same cycle", adv, 5'b11100);
    cyc(); rsv_rel = 0; #2;
    chk("R11 wrong tag release ignored", adv, 5'b11100);
    cyc(); rsv_rel = 1; rel_tag = 8'h11; #2;
    chk("R11 owner release not yet", adv, 5'b11100);
    cyc(); rsv_rel = 0; #2;
    chk("R11 owner release effective", adv, 5'h1f);
    cyc(); rsv_req = 1; rsv_stg = 3'd0; rsv_tag = 8'h44; #2;
    chk("R10 fetch not reservable", grant, 0);
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    t_reset();
    t_flow();
    t_stall();
    t_load_use();
    t_fwd();
    t_freeze();
    t_resv();
    cyc();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule